// File: doc/BRIEF.md
# Byte-Wide Memory DMA Engine

This block copies words between an 8-bit external byte memory and on-chip word memory. Each word is 24, 16 or 8 bits wide. The block builds a word from successive byte reads, or breaks a word into successive byte writes. Software first programs the word format, the direction, the halt option and the wait-state count. It then programs the on-chip start address and the external page and offset. Writing a nonzero word count starts the transfer.

The external byte address is 22 bits wide. An 8-bit page sits above a 14-bit offset, and the two step together as one counter, so a transfer runs straight across page boundaries. Every byte access holds its strobe for a programmable number of extra cycles. A byte access does not begin while the core is requesting the external bus. Each finished word uses exactly one on-chip memory cycle. The remaining count falls by one per word. The end of the transfer raises a one-cycle interrupt. In the optional halt mode, the core is held for the whole transfer and then given a one-cycle restart pulse, which clears its context so that it starts again at address zero.

Top module: `bdx_engine`

## Requirements
- R1: After reset, busy, irq, core_hold, core_restart, bm_rd, bm_wr and mem_req are 0, words_left is 0, and bm_addr is 0.
- R2: While idle, a write with cfg_sel=4 and a nonzero value in cfg_wdata[13:0] makes busy high in the next cycle and loads words_left with that value. A write of zero to cfg_sel=4 starts nothing.
- R3: Control register (cfg_sel=0): bits [1:0] are the format, bit 2 is the direction (0 = byte memory to on-chip memory, 1 = on-chip memory to byte memory), bit 3 is halt, and bits [6:4] are the wait states. In a load with format 00, three bytes form mem_wdata[23:0] with mem_pm=1. With format 01, two bytes form mem_wdata[15:0] with mem_pm=0 and [23:16]=0. In both formats the first byte, read at the lowest address, is the most significant.
- R4: In a load with format 10, the byte goes to mem_wdata[15:8]. With format 11 it goes to mem_wdata[7:0]. All other bits are 0 and mem_pm=0.
- R5: In a store, bm_wdata carries the on-chip word most significant byte first, at rising addresses. Format 00 sends [23:16], [15:8] and [7:0]. Format 01 sends [15:8] and [7:0]. Format 10 sends [15:8]. Format 11 sends [7:0].
- R6: bm_addr is {page (cfg_sel=3, 8 bits), offset (cfg_sel=2, 14 bits)}. It rises by one after each byte and carries from the offset into the page. 22'h3FFFFF wraps to 0.
- R7: Each byte access holds bm_rd (load) or bm_wr (store) for wait+1 cycles, with bm_addr steady. The two strobes are never high together.
- R8: A byte access never starts in the cycle after one in which core_ext_req was high.
- R9: Each word uses one mem_req cycle. mem_addr starts at the value written to cfg_sel=1 and rises by one per word.
- R10: With no bus contention, each word takes bytes*(wait+2)+1 cycles. words_left drops by one at the end of each word. busy lasts words*(bytes*(wait+2)+1) cycles.
- R11: irq is high for exactly one cycle, the first cycle after busy falls.
- R12: With halt=1, core_hold equals busy, and core_restart pulses together with irq. With halt=0, both stay low.
- R13: Configuration writes made while busy have no effect, including writes to the page, offset and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1 on-chip address, 2 offset, 3 page, 4 count |
| cfg_wdata | input | 14 | Configuration write data |
| busy | output | 1 | Transfer in progress |
| words_left | output | 14 | Words still to move |
| irq | output | 1 | One-cycle completion pulse |
| core_ext_req | input | 1 | Core wants the external bus (takes priority) |
| core_hold | output | 1 | Stall the core (halt mode) |
| core_restart | output | 1 | Restart the core at address 0 after a halted transfer |
| bm_addr | output | 22 | Byte memory address |
| bm_rd | output | 1 | Byte read strobe |
| bm_wr | output | 1 | Byte write strobe |
| bm_wdata | output | 8 | Byte write data |
| bm_rdata | input | 8 | Byte read data |
| mem_req | output | 1 | On-chip memory access cycle |
| mem_we | output | 1 | On-chip write (load direction) |
| mem_pm | output | 1 | Selects program memory (format 00) |
| mem_addr | output | 14 | On-chip word address |
| mem_wdata | output | 24 | Word written on-chip |
| mem_rdata | input | 24 | Word read on-chip, valid in the same cycle |

## Verification
Counting from the first cycle after the count write, the bench computes for every cycle the expected busy, words_left, core_hold, irq and core_restart. words_left falls exactly at each multiple of bytes*(wait+2)+1 cycles. irq and core_restart are due only at cycle words times that figure. Byte and word events are checked when they show up on the strobes, not at fixed times. Each strobe run is measured against wait+1, its address is compared with the next expected byte address, and store data is checked when the strobe falls. During contention only these event checks run, and a strobe must never start right after a cycle in which core_ext_req was high. All outputs are sampled on the falling edge, half a cycle after the registers update.

// File: rtl/bdx_pkg.sv
package bdx_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 24;
    localparam int WAIT_W = 3;

    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_IADDR = 3'd1;
    localparam logic [2:0] SEL_OFS   = 3'd2;
    localparam logic [2:0] SEL_PAGE  = 3'd3;
    localparam logic [2:0] SEL_COUNT = 3'd4;

    typedef enum logic [1:0] {
        FMT_PM24  = 2'b00,
        FMT_DM16  = 2'b01,
        FMT_DM8HI = 2'b10,
        FMT_DM8LO = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GRANT,
        ST_BYTE,
        ST_WORD
    } state_e;

    // field order gives control bits [6:4]=waits, [3]=halt, [2]=dir, [1:0]=fmt
    typedef struct packed {
        logic [WAIT_W-1:0] waits;
        logic              halt;
        logic              dir;
        fmt_e              fmt;
    } ctrl_t;

    function automatic logic [1:0] bytes_per_word(fmt_e f);
        case (f)
            FMT_PM24: return 2'd3;
            FMT_DM16: return 2'd2;
            default:  return 2'd1;
        endcase
    endfunction

    // the newest byte sits in sh[7:0]; earlier bytes sit above it
    function automatic logic [WORD_W-1:0] pack_word(fmt_e f, logic [WORD_W-1:0] sh);
        case (f)
            FMT_PM24:  return sh;
            FMT_DM16:  return {8'h00, sh[15:0]};
            FMT_DM8HI: return {8'h00, sh[7:0], 8'h00};
            default:   return {16'h0000, sh[7:0]};
        endcase
    endfunction

    // place the first byte to send in the top byte of the shifter
    function automatic logic [WORD_W-1:0] align_for_split(fmt_e f, logic [WORD_W-1:0] w);
        case (f)
            FMT_PM24:  return w;
            FMT_DM16:  return {w[15:0], 8'h00};
            FMT_DM8HI: return {w[15:8], 16'h0000};
            default:   return {w[7:0], 16'h0000};
        endcase
    endfunction
endpackage

// File: rtl/bdx_addr.sv
module bdx_addr #(
    parameter int PAGE_W = 8,
    parameter int OFS_W  = 14,
    parameter int DATA_W = 14
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ld_page,
    input  logic                     ld_ofs,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     step,
    output logic [PAGE_W+OFS_W-1:0]  addr
);
    localparam int ADDR_W = PAGE_W + OFS_W;

    logic [PAGE_W-1:0] page_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [ADDR_W-1:0] next_addr;

    assign next_addr = {page_q, ofs_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            ofs_q  <= '0;
        end else if (step) begin
            {page_q, ofs_q} <= next_addr;
        end else begin
            if (ld_page) page_q <= wdata[PAGE_W-1:0];
            if (ld_ofs)  ofs_q  <= wdata[OFS_W-1:0];
        end
    end

    assign addr = {page_q, ofs_q};
endmodule

// File: rtl/bdx_pack.sv
module bdx_pack
    import bdx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fmt_e              fmt,
    input  logic              dir,
    input  logic              ld_word,
    input  logic [WORD_W-1:0] word_in,
    input  logic              shift,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic [WORD_W-1:0] word_out
);
    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (ld_word) begin
            sh_q <= align_for_split(fmt, word_in);
        end else if (shift) begin
            sh_q <= {sh_q[WORD_W-BYTE_W-1:0], (dir ? {BYTE_W{1'b0}} : byte_in)};
        end
    end

    assign byte_out = sh_q[WORD_W-1 -: BYTE_W];
    assign word_out = pack_word(fmt, sh_q);
endmodule

// File: rtl/bdx_ctrl.sv
module bdx_ctrl
    import bdx_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  count_in,
    input  logic              dir,
    input  fmt_e              fmt,
    input  logic [WAIT_W-1:0] waits,
    input  logic              halt,
    input  logic              bus_req,
    output state_e            state,
    output logic              busy,
    output logic [CNT_W-1:0]  words_left,
    output logic              byte_done,
    output logic              irq,
    output logic              restart
);
    state_e            st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WAIT_W-1:0] wcnt_q;
    logic [1:0]        bidx_q;
    logic              last_byte;
    logic              last_word;

    assign last_byte = (bidx_q == bytes_per_word(fmt) - 2'd1);
    assign last_word = (cnt_q == CNT_W'(1));
    assign byte_done = (st_q == ST_BYTE) && (wcnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            wcnt_q  <= '0;
            bidx_q  <= '0;
            irq     <= 1'b0;
            restart <= 1'b0;
        end else begin
            irq     <= 1'b0;
            restart <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        cnt_q  <= count_in;
                        bidx_q <= '0;
                        st_q   <= dir ? ST_WORD : ST_GRANT;
                    end
                end
                ST_GRANT: begin
                    if (!bus_req) begin
                        wcnt_q <= waits;
                        st_q   <= ST_BYTE;
                    end
                end
                ST_BYTE: begin
                    if (wcnt_q != '0) begin
                        wcnt_q <= wcnt_q - 1'b1;
                    end else if (!last_byte) begin
                        bidx_q <= bidx_q + 1'b1;
                        st_q   <= ST_GRANT;
                    end else begin
                        bidx_q <= '0;
                        if (!dir) begin
                            st_q <= ST_WORD;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                            if (last_word) begin
                                st_q    <= ST_IDLE;
                                irq     <= 1'b1;
                                restart <= halt;
                            end else begin
                                st_q <= ST_WORD;
                            end
                        end
                    end
                end
                ST_WORD: begin
                    if (dir) begin
                        st_q <= ST_GRANT;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                        if (last_word) begin
                            st_q    <= ST_IDLE;
                            irq     <= 1'b1;
                            restart <= halt;
                        end else begin
                            st_q <= ST_GRANT;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign state      = st_q;
    assign busy       = (st_q != ST_IDLE);
    assign words_left = cnt_q;
endmodule

// File: rtl/bdx_engine.sv
module bdx_engine
    import bdx_pkg::*;
#(
    parameter int PAGE_W  = 8,
    parameter int OFS_W   = 14,
    parameter int CNT_W   = 14,
    parameter int IADDR_W = 14,
    parameter int CFG_W   = 14
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [2:0]                cfg_sel,
    input  logic [CFG_W-1:0]          cfg_wdata,
    output logic                      busy,
    output logic [CNT_W-1:0]          words_left,
    output logic                      irq,
    input  logic                      core_ext_req,
    output logic                      core_hold,
    output logic                      core_restart,
    output logic [PAGE_W+OFS_W-1:0]   bm_addr,
    output logic                      bm_rd,
    output logic                      bm_wr,
    output logic [BYTE_W-1:0]         bm_wdata,
    input  logic [BYTE_W-1:0]         bm_rdata,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic                      mem_pm,
    output logic [IADDR_W-1:0]        mem_addr,
    output logic [WORD_W-1:0]         mem_wdata,
    input  logic [WORD_W-1:0]         mem_rdata
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t               cfg_q;
    logic [IADDR_W-1:0]  ia_q;
    state_e              st;
    logic                busy_i;
    logic                byte_done;
    logic                wr_ok;
    logic                start;
    logic                word_cyc;

    assign wr_ok    = cfg_we && !busy_i;
    assign start    = wr_ok && (cfg_sel == SEL_COUNT) && (cfg_wdata[CNT_W-1:0] != '0);
    assign word_cyc = (st == ST_WORD);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            ia_q  <= '0;
        end else begin
            if (wr_ok && cfg_sel == SEL_CTRL)
                cfg_q <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            if (wr_ok && cfg_sel == SEL_IADDR)
                ia_q <= cfg_wdata[IADDR_W-1:0];
            else if (word_cyc)
                ia_q <= ia_q + 1'b1;
        end
    end

    bdx_addr #(
        .PAGE_W (PAGE_W),
        .OFS_W  (OFS_W),
        .DATA_W (CFG_W)
    ) u_addr (
        .clk     (clk),
        .rst     (rst),
        .ld_page (wr_ok && cfg_sel == SEL_PAGE),
        .ld_ofs  (wr_ok && cfg_sel == SEL_OFS),
        .wdata   (cfg_wdata),
        .step    (byte_done),
        .addr    (bm_addr)
    );

    bdx_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .fmt      (cfg_q.fmt),
        .dir      (cfg_q.dir),
        .ld_word  (word_cyc && cfg_q.dir),
        .word_in  (mem_rdata),
        .shift    (byte_done),
        .byte_in  (bm_rdata),
        .byte_out (bm_wdata),
        .word_out (mem_wdata)
    );

    bdx_ctrl #(
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .count_in   (cfg_wdata[CNT_W-1:0]),
        .dir        (cfg_q.dir),
        .fmt        (cfg_q.fmt),
        .waits      (cfg_q.waits),
        .halt       (cfg_q.halt),
        .bus_req    (core_ext_req),
        .state      (st),
        .busy       (busy_i),
        .words_left (words_left),
        .byte_done  (byte_done),
        .irq        (irq),
        .restart    (core_restart)
    );

    assign busy      = busy_i;
    assign core_hold = busy_i && cfg_q.halt;
    assign bm_rd     = (st == ST_BYTE) && !cfg_q.dir;
    assign bm_wr     = (st == ST_BYTE) && cfg_q.dir;
    assign mem_req   = word_cyc;
    assign mem_we    = !cfg_q.dir;
    assign mem_pm    = (cfg_q.fmt == FMT_PM24);
    assign mem_addr  = ia_q;
endmodule

// File: rtl/bdx_checker.sv
module bdx_checker #(
    parameter int ADDR_W = 22,
    parameter int CNT_W  = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              irq,
    input logic              core_ext_req,
    input logic              core_hold,
    input logic              bm_rd,
    input logic              bm_wr,
    input logic [ADDR_W-1:0] bm_addr,
    input logic              mem_req,
    input logic [CNT_W-1:0]  words_left
);
    logic strobe;
    assign strobe = bm_rd | bm_wr;

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(bm_rd && bm_wr));

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (strobe && $past(strobe)) |-> $stable(bm_addr));

    p_yield_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe) |-> !$past(core_ext_req));

    p_word_once_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    p_count_down_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (words_left <= $past(words_left)));

    p_irq_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    p_irq_at_end_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq);

    p_hold_busy_r12: assert property (@(posedge clk) disable iff (rst)
        core_hold |-> busy);
endmodule

bind bdx_engine bdx_checker #(
    .ADDR_W (PAGE_W + OFS_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .irq          (irq),
    .core_ext_req (core_ext_req),
    .core_hold    (core_hold),
    .bm_rd        (bm_rd),
    .bm_wr        (bm_wr),
    .bm_addr      (bm_addr),
    .mem_req      (mem_req),
    .words_left   (words_left)
);

// File: tb/bdx_engine_tb.sv
module bdx_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [13:0] cfg_wdata = 14'd0;
    logic        busy, irq, core_hold, core_restart;
    logic [13:0] words_left;
    logic        core_ext_req = 1'b0;
    logic [21:0] bm_addr;
    logic        bm_rd, bm_wr;
    logic [7:0]  bm_wdata, bm_rdata;
    logic        mem_req, mem_we, mem_pm;
    logic [13:0] mem_addr;
    logic [23:0] mem_wdata, mem_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] bfun(logic [21:0] a);
        return 8'(a[7:0] * 8'd7 + 8'd3) ^ a[15:8] ^ {2'b00, a[21:16]};
    endfunction

    function automatic logic [23:0] wfun(logic [13:0] a, logic pm);
        return pm ? {a[7:0] ^ 8'hC3, a[13:6], ~a[7:0]}
                  : {8'hEE, a[7:0] ^ 8'h3C, ~a[13:6]};
    endfunction

    assign bm_rdata  = bfun(bm_addr);
    assign mem_rdata = wfun(mem_addr, mem_pm);

    bdx_engine u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .busy(busy), .words_left(words_left), .irq(irq), .core_ext_req(core_ext_req),
        .core_hold(core_hold), .core_restart(core_restart), .bm_addr(bm_addr),
        .bm_rd(bm_rd), .bm_wr(bm_wr), .bm_wdata(bm_wdata), .bm_rdata(bm_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_pm(mem_pm), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int sel, int data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = 3'(sel);
        cfg_wdata = 14'(data);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    function automatic int nbytes(int fmt);
        return (fmt == 0) ? 3 : (fmt == 1) ? 2 : 1;
    endfunction

    function automatic logic [23:0] exp_load(int fmt, int base, int w);
        int nb = nbytes(fmt);
        logic [7:0] b0, b1, b2;
        b0 = bfun(22'(base + w * nb));
        b1 = bfun(22'(base + w * nb + 1));
        b2 = bfun(22'(base + w * nb + 2));
        case (fmt)
            0:       return {b0, b1, b2};
            1:       return {8'h00, b0, b1};
            2:       return {8'h00, b0, 8'h00};
            default: return {16'h0000, b0};
        endcase
    endfunction

    function automatic logic [7:0] exp_store(int fmt, int ia, int j);
        int nb = nbytes(fmt);
        int i  = j % nb;
        logic [23:0] w;
        w = wfun(14'(ia + j / nb), fmt == 0);
        case (fmt)
            0:       return (i == 0) ? w[23:16] : (i == 1) ? w[15:8] : w[7:0];
            1:       return (i == 0) ? w[15:8] : w[7:0];
            2:       return w[15:8];
            default: return w[7:0];
        endcase
    endfunction

    task automatic run(int fmt, bit dir, bit halt, int ws, int ia, int page, int ofs,
                       int words, bit arb, bit poke);
        int nb    = nbytes(fmt);
        int per   = nb * (ws + 2) + 1;
        int total = words * per;
        int base  = page * 16384 + ofs;
        int bi = 0, wi = 0, run_len = 0, idle_run = 0;
        bit prev_st = 0, prev_req = 0, prev_busy = 1;
        logic [7:0] cap = 8'h00;
        wr(0, (ws << 4) | (int'(halt) << 3) | (int'(dir) << 2) | fmt);
        wr(1, ia);
        wr(2, ofs);
        wr(3, page);
        wr(4, words);
        for (int k = 0; k < 4000; k++) begin
            bit st = bm_rd | bm_wr;
            bit fin = prev_busy && !busy;
            if (!arb) begin
                chk(busy == (k < total), "R10 busy", busy, k < total);
                chk(words_left == 14'((k < total) ? words - k / per : 0), "R10 words_left",
                    words_left, (k < total) ? words - k / per : 0);
                if (k == 0) chk(busy == 1'b1, "R2 start", busy, 1);
            end
            chk(irq == fin, "R11 irq", irq, fin);
            chk(core_restart == (fin && halt), "R12 restart", core_restart, fin && halt);
            chk(core_hold == (busy && halt), "R12 hold", core_hold, busy && halt);
            chk(!(bm_rd && bm_wr), "R7 exclusive", {bm_rd, bm_wr}, 0);
            if (st) begin
                chk(bm_rd == !dir, "R3 direction", bm_rd, !dir);
                chk(bm_addr == 22'(base + bi), "R6 address", bm_addr, 22'(base + bi));
                if (!prev_st) chk(prev_req == 1'b0, "R8 yield", prev_req, 0);
                cap = bm_wdata;
                run_len++;
            end else if (prev_st) begin
                chk(run_len == ws + 1, "R7 strobe width", run_len, ws + 1);
                if (dir) chk(cap == exp_store(fmt, ia, bi), "R5 store byte", cap,
                             exp_store(fmt, ia, bi));
                bi++;
                run_len = 0;
            end
            if (mem_req) begin
                chk(mem_we == !dir, "R9 mem_we", mem_we, !dir);
                chk(mem_pm == (fmt == 0), "R3 mem_pm", mem_pm, fmt == 0);
                chk(mem_addr == 14'(ia + wi), "R9 mem_addr", mem_addr, 14'(ia + wi));
                if (!dir) chk(mem_wdata == exp_load(fmt, base, wi),
                              (fmt >= 2) ? "R4 load word" : "R3 load word",
                              mem_wdata, exp_load(fmt, base, wi));
                wi++;
            end
            prev_st   = st;
            prev_busy = busy;
            idle_run  = busy ? 0 : idle_run + 1;
            core_ext_req = arb && ((k % 5 == 1) || (k % 5 == 2) || (k % 7 == 0));
            prev_req     = core_ext_req;
            if (poke && k == 2)      begin cfg_we = 1; cfg_sel = 3'd2; cfg_wdata = 14'h0000; end
            else if (poke && k == 3) begin cfg_we = 1; cfg_sel = 3'd3; cfg_wdata = 14'h0055; end
            else if (poke && k == 4) begin cfg_we = 1; cfg_sel = 3'd4; cfg_wdata = 14'd9; end
            else cfg_we = 0;
            if (idle_run == 2) break;
            @(negedge clk);
        end
        core_ext_req = 0;
        cfg_we = 0;
        chk(bi == words * nb, "R10 byte total", bi, words * nb);
        chk(wi == words, "R9 word total", wi, words);
        chk(bm_addr == 22'(base + words * nb), poke ? "R13 address kept" : "R6 final address",
            bm_addr, 22'(base + words * nb));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(busy == 0, "R1 busy", busy, 0);
        chk({bm_rd, bm_wr, mem_req, irq, core_hold, core_restart} == 6'b0, "R1 strobes",
            {bm_rd, bm_wr, mem_req, irq, core_hold, core_restart}, 0);
        chk(words_left == 0, "R1 words_left", words_left, 0);
        chk(bm_addr == 0, "R1 bm_addr", bm_addr, 0);

        wr(4, 0);
        chk(busy == 0, "R2 zero count", busy, 0);
        @(negedge clk);
        chk(busy == 0, "R2 zero count later", busy, 0);

        run(0, 0, 1, 0, 14'h0010, 8'h03, 14'h3FFE, 3, 0, 0);
        run(1, 0, 0, 2, 14'h0100, 8'h12, 14'h0040, 2, 0, 0);
        run(2, 0, 0, 1, 14'h0200, 8'h01, 14'h0007, 2, 0, 0);
        run(3, 0, 1, 0, 14'h3FFF, 8'h20, 14'h1000, 2, 0, 0);
        run(0, 1, 0, 1, 14'h0030, 8'h04, 14'h0100, 2, 0, 0);
        run(1, 1, 1, 0, 14'h0031, 8'h05, 14'h3FFF, 2, 0, 0);
        run(2, 1, 0, 3, 14'h0032, 8'h06, 14'h0200, 2, 0, 0);
        run(3, 1, 0, 0, 14'h0033, 8'h07, 14'h0300, 3, 0, 0);
        run(1, 0, 0, 0, 14'h0000, 8'hFF, 14'h3FFF, 1, 0, 0);
        run(0, 0, 0, 1, 14'h0050, 8'h08, 14'h0010, 2, 1, 0);
        run(1, 1, 0, 1, 14'h0060, 8'h09, 14'h0020, 2, 1, 0);
        run(0, 0, 0, 1, 14'h0070, 8'h0A, 14'h0030, 2, 0, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule